// File: doc/BRIEF.md
# Two-level page table walker

This block turns a virtual page number into a physical page number by reading a two-level page table held in memory. A 32-bit virtual address is split 10/10/12: the top ten bits select an entry in the first-level table, the next ten select an entry in a second-level table, and the low twelve are the offset inside a 4 KiB page. The offset needs no translation, so the block takes only the 20-bit page number and returns only the 20-bit physical page number.

A walk starts when a request is accepted. The block captures the page number, the access type and the table root address supplied by the operating system for the running process. It then issues one read for the first-level entry. If that entry marks a resident table, it issues a second read for the leaf entry. Reads go through a single-beat memory port whose acknowledge may arrive any number of cycles after the request.

The result is a one-cycle response carrying the page number, the leaf permissions and two fault flags. The page-fault flag means a table or page is absent; this includes entries whose upper bits hold a disk location instead of a frame number. The protection-fault flag means the leaf exists but forbids the requested access. The control is a six-state machine:

- IDLE waits for a request.
- L1_REQ issues the first read.
- L1_WAIT waits for its acknowledge. An invalid entry goes to RESP and a valid one goes to L2_REQ.
- L2_REQ issues the leaf read.
- L2_WAIT waits for the leaf data.
- RESP presents the result for one cycle and returns to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: After reset the block shows `req_ready`=1, `mem_req`=0 and `rsp_valid`=0.
- R2: The first read address is `root_ptr` + 4 × `req_vpn[19:10]` (virtual address bits 31:22), using the root value captured when the request was accepted.
- R3: The second read address is (first-level entry bits 31:12 shifted left by 12) + 4 × `req_vpn[9:0]` (virtual address bits 21:12).
- R4: An entry is decoded as follows: bit 0 is valid, bit 1 is read, bit 2 is write, bit 3 is execute, and bits 31:12 are the frame number. The permission bits of the first-level entry are ignored. A successful walk returns the leaf frame number on `rsp_ppn` and returns `rsp_perm` = {X,W,R} with both fault flags low.
- R5: A first-level entry with bit 0 clear ends the walk with `rsp_page_fault`=1 after exactly one memory read. Its other bits are ignored, and `rsp_ppn` and `rsp_perm` are zero.
- R6: A leaf entry with bit 0 clear gives `rsp_page_fault`=1 and `rsp_prot_fault`=0, with `rsp_ppn` and `rsp_perm` zero.
- R7: `req_acc` is encoded as 0 for load (needs R), 1 for store (needs W), 2 for fetch (needs X), and 3 is reserved and never permitted. A valid leaf lacking the needed bit gives `rsp_prot_fault`=1 and `rsp_page_fault`=0, and still reports the leaf frame number and permissions.
- R8: Each memory read is a single-cycle `mem_req` pulse. No new pulse is issued while a read waits for `mem_ack`, and any latency of one cycle or more is accepted.
- R9: `req_ready` is high only in IDLE. While a walk runs, changes on `req_valid`, `req_vpn` and `root_ptr` have no effect on it.
- R10: `rsp_valid` lasts exactly one cycle and never has both fault flags set. The block is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 32 | Byte address of the current first-level table |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vpn | input | 20 | Virtual page number (address bits 31:12) |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Response strobe |
| rsp_ppn | output | 20 | Physical page number |
| rsp_perm | output | 3 | Leaf permissions {X,W,R} |
| rsp_page_fault | output | 1 | Table or page not resident |
| rsp_prot_fault | output | 1 | Access type not permitted by leaf |

## Verification
The bound checker watches the memory port and the response on every cycle. It checks the following:
- Read pulses are single cycles, and no pulse is issued while a read is outstanding.
- The first read address matches the root and index captured at acceptance.
- The response strobe lasts one cycle and never carries both fault kinds.
- Page faults return zeroed data.

Only the directed scenarios can show that entry bits are decoded correctly, that the second-level address is built from the first entry's frame number, that each access type is matched to the right permission, and that input changes during a walk leave it untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTE_BIT_V = 0;
    localparam int PTE_BIT_R = 1;
    localparam int PTE_BIT_W = 2;
    localparam int PTE_BIT_X = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [DATA_W-1:0]       pte,
    input  logic [1:0]              acc,
    output logic                    present,
    output logic [2:0]              perm,
    output logic [DATA_W-OFF_W-1:0] ppn,
    output logic                    allowed
);

    logic unused_bits;
    assign unused_bits = ^pte[OFF_W-1:PTE_BIT_X+1];

    assign present = pte[PTE_BIT_V];
    assign perm    = {pte[PTE_BIT_X], pte[PTE_BIT_W], pte[PTE_BIT_R]};
    assign ppn     = pte[DATA_W-1:OFF_W];

    always_comb begin
        unique case (acc)
            ACC_LOAD:  allowed = perm[0];
            ACC_STORE: allowed = perm[1];
            ACC_FETCH: allowed = perm[2];
            default:   allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_SHIFT = 2
) (
    input  logic [ADDR_W-1:0]       root,
    input  logic [2*IDX_W-1:0]      vpn,
    input  logic [ADDR_W-OFF_W-1:0] table_ppn,
    input  logic                    second,
    output logic [ADDR_W-1:0]       addr
);

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        idx  = second ? vpn[IDX_W-1:0] : vpn[2*IDX_W-1:IDX_W];
        base = second ? {table_ppn, {OFF_W{1'b0}}} : root;
        offs = ADDR_W'(idx) << PTE_SHIFT;
        addr = base + offs;
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PTE_SZ = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       root_ptr,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2*IDX_W-1:0]      req_vpn,
    input  logic [1:0]              req_acc,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [ADDR_W-1:0]       mem_rdata,
    output logic                    rsp_valid,
    output logic [ADDR_W-OFF_W-1:0] rsp_ppn,
    output logic [2:0]              rsp_perm,
    output logic                    rsp_page_fault,
    output logic                    rsp_prot_fault
);

    localparam int PPN_W     = ADDR_W - OFF_W;
    localparam int VPN_W     = 2 * IDX_W;
    localparam int PTE_SHIFT = $clog2(PTE_SZ);

    walk_state_e state_q, state_d;

    logic [VPN_W-1:0]  vpn_q;
    logic [1:0]        acc_q;
    logic [ADDR_W-1:0] root_q;
    logic [PPN_W-1:0]  tbl_ppn_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [2:0]        perm_q;
    logic              pf_q;
    logic              prot_q;

    logic              dec_present;
    logic [2:0]        dec_perm;
    logic [PPN_W-1:0]  dec_ppn;
    logic              dec_allowed;

    ptw_pte_decode #(.DATA_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
        .pte     (mem_rdata),
        .acc     (acc_q),
        .present (dec_present),
        .perm    (dec_perm),
        .ppn     (dec_ppn),
        .allowed (dec_allowed)
    );

    ptw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_SHIFT(PTE_SHIFT)) u_agen (
        .root      (root_q),
        .vpn       (vpn_q),
        .table_ppn (tbl_ppn_q),
        .second    (state_q == S_L2_REQ),
        .addr      (mem_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_L1_REQ;
            S_L1_REQ:  state_d = S_L1_WAIT;
            S_L1_WAIT: if (mem_ack) state_d = dec_present ? S_L2_REQ : S_RESP;
            S_L2_REQ:  state_d = S_L2_WAIT;
            S_L2_WAIT: if (mem_ack) state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q     <= '0;
            acc_q     <= '0;
            root_q    <= '0;
            tbl_ppn_q <= '0;
            ppn_q     <= '0;
            perm_q    <= '0;
            pf_q      <= 1'b0;
            prot_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    vpn_q  <= req_vpn;
                    acc_q  <= req_acc;
                    root_q <= root_ptr;
                    ppn_q  <= '0;
                    perm_q <= '0;
                    pf_q   <= 1'b0;
                    prot_q <= 1'b0;
                end
                S_L1_WAIT: if (mem_ack) begin
                    if (dec_present) tbl_ppn_q <= dec_ppn;
                    else             pf_q      <= 1'b1;
                end
                S_L2_WAIT: if (mem_ack) begin
                    if (!dec_present) begin
                        pf_q <= 1'b1;
                    end else begin
                        ppn_q  <= dec_ppn;
                        perm_q <= dec_perm;
                        prot_q <= !dec_allowed;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready      = (state_q == S_IDLE);
        mem_req        = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
        rsp_valid      = (state_q == S_RESP);
        rsp_ppn        = ppn_q;
        rsp_perm       = perm_q;
        rsp_page_fault = pf_q;
        rsp_prot_fault = prot_q;
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       root_ptr,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [2*IDX_W-1:0]      req_vpn,
    input logic                    mem_req,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic                    mem_ack,
    input logic                    rsp_valid,
    input logic [ADDR_W-OFF_W-1:0] rsp_ppn,
    input logic [2:0]              rsp_perm,
    input logic                    rsp_page_fault,
    input logic                    rsp_prot_fault
);

    logic              pending;
    logic              need_first;
    logic [ADDR_W-1:0] exp_first;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            need_first <= 1'b0;
            exp_first  <= '0;
        end else begin
            if (mem_req)      pending <= 1'b1;
            else if (mem_ack) pending <= 1'b0;
            if (req_valid && req_ready) begin
                need_first <= 1'b1;
                exp_first  <= root_ptr + (ADDR_W'(req_vpn[2*IDX_W-1:IDX_W]) << 2);
            end else if (mem_req) begin
                need_first <= 1'b0;
            end
        end
    end

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (need_first && mem_req) |-> (mem_addr == exp_first)); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R8
    AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !mem_req); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid)); // R9
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R10
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault)); // R10
    AST_PF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_page_fault) |-> (rsp_ppn == '0 && rsp_perm == 3'b000)); // R6

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .root_ptr       (root_ptr),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vpn        (req_vpn),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_ack        (mem_ack),
    .rsp_valid      (rsp_valid),
    .rsp_ppn        (rsp_ppn),
    .rsp_perm       (rsp_perm),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_ptr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [19:0] rsp_ppn;
    logic [2:0]  rsp_perm;
    logic        rsp_page_fault;
    logic        rsp_prot_fault;

    int n_checks = 0;
    int n_errors = 0;
    int lat = 1;
    int n_acc = 0;
    logic [31:0] addr_log [4];
    logic [31:0] mem [logic [31:0]];

    logic [19:0] got_ppn;
    logic [2:0]  got_perm;
    logic        got_pf, got_prot, got_seen;

    always #2 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_acc(req_acc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault)
    );

    // memory model: one-cycle request, acknowledge after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (n_acc < 4) addr_log[n_acc] = mem_addr;
                n_acc++;
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                repeat (lat - 1) @(negedge clk);
                @(negedge clk);
                mem_ack = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] l1_addr(input logic [31:0] root, input logic [19:0] vpn);
        return root + {20'h0, vpn[19:10], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] pte, input logic [19:0] vpn);
        return {pte[31:12], 12'h000} + {20'h0, vpn[9:0], 2'b00};
    endfunction

    task automatic run_walk(input logic [19:0] vpn, input logic [1:0] acc,
                            input logic [31:0] root, input bit disturb);
        n_acc = 0;
        got_seen = 1'b0;
        @(negedge clk);
        req_vpn = vpn; req_acc = acc; root_ptr = root; req_valid = 1'b1;
        @(negedge clk);
        if (disturb) begin
            req_vpn = ~vpn; root_ptr = root ^ 32'h0F0F_0000; req_acc = 2'd3;
            chk("R9 ready low while busy", {31'h0, req_ready}, 32'h0);
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 200 && !got_seen; i++) begin
            if (rsp_valid) begin
                got_seen = 1'b1;
                got_ppn = rsp_ppn; got_perm = rsp_perm;
                got_pf = rsp_page_fault; got_prot = rsp_prot_fault;
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R10 response seen", {31'h0, got_seen}, 32'h1);
        @(negedge clk);
        chk("R10 strobe one cycle", {31'h0, rsp_valid}, 32'h0);
        chk("R10 ready after response", {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_success_fast;
        logic [19:0] v = {10'h2A5, 10'h13C};
        logic [31:0] r = 32'h0001_0000;
        logic [31:0] p1 = 32'h0034_50F1;  // valid, perm bits of L1 ignored
        mem.delete(); lat = 1;
        mem[l1_addr(r, v)] = p1;
        mem[l2_addr(p1, v)] = 32'hABCD_E00F;
        run_walk(v, 2'd0, r, 1'b0);
        chk("R8 two reads", n_acc, 2);
        chk("R2 first address", addr_log[0], 32'h0001_0A94);
        chk("R3 second address", addr_log[1], 32'h0034_54F0);
        chk("R4 ppn", {12'h0, got_ppn}, 32'hABCDE);
        chk("R4 perm", {29'h0, got_perm}, 32'h7);
        chk("R4 no faults", {30'h0, got_pf, got_prot}, 32'h0);
    endtask

    task automatic t_success_slow;
        logic [19:0] v = {10'h000, 10'h3FF};
        logic [31:0] r = 32'h0020_0000;
        logic [31:0] p1 = 32'h0000_1001;
        mem.delete(); lat = 5;
        mem[l1_addr(r, v)] = p1;
        mem[l2_addr(p1, v)] = 32'h7777_700B;
        run_walk(v, 2'd2, r, 1'b0);
        chk("R8 latency 5 two reads", n_acc, 2);
        chk("R3 top-index address", addr_log[1], 32'h0000_1FFC);
        chk("R7 fetch allowed ppn", {12'h0, got_ppn}, 32'h77777);
        chk("R4 perm X,R", {29'h0, got_perm}, 32'h5);
        chk("R7 fetch no fault", {30'h0, got_pf, got_prot}, 32'h0);
    endtask

    task automatic t_l1_fault;
        logic [19:0] v = {10'h3FF, 10'h001};
        logic [31:0] r = 32'h0003_0000;
        mem.delete(); lat = 3;
        mem[l1_addr(r, v)] = 32'hFFFF_F0EE;  // disk page number, valid clear
        run_walk(v, 2'd0, r, 1'b0);
        chk("R5 single read", n_acc, 1);
        chk("R2 last-index address", addr_log[0], 32'h0003_0FFC);
        chk("R5 page fault", {30'h0, got_pf, got_prot}, 32'h2);
        chk("R5 zero data", {9'h0, got_perm, got_ppn}, 32'h0);
    endtask

    task automatic t_l2_fault;
        logic [19:0] v = {10'h011, 10'h022};
        logic [31:0] r = 32'h0004_0000;
        logic [31:0] p1 = 32'h0009_9001;
        mem.delete(); lat = 2;
        mem[l1_addr(r, v)] = p1;
        mem[l2_addr(p1, v)] = 32'h1234_500E;
        run_walk(v, 2'd1, r, 1'b0);
        chk("R6 two reads", n_acc, 2);
        chk("R6 page fault", {30'h0, got_pf, got_prot}, 32'h2);
        chk("R6 zero data", {9'h0, got_perm, got_ppn}, 32'h0);
    endtask

    task automatic t_prot(input logic [1:0] acc, input string tag);
        logic [19:0] v = {10'h155, 10'h0AA};
        logic [31:0] r = 32'h0005_0000;
        logic [31:0] p1 = 32'h0008_8001;
        mem.delete(); lat = 1;
        mem[l1_addr(r, v)] = p1;
        mem[l2_addr(p1, v)] = 32'h5555_500B;
        run_walk(v, acc, r, 1'b0);
        chk(tag, {30'h0, got_pf, got_prot}, 32'h1);
        chk("R7 leaf still reported", {9'h0, got_perm, got_ppn}, {9'h0, 3'b101, 20'h55555});
    endtask

    task automatic t_busy;
        logic [19:0] v = {10'h0C3, 10'h21D};
        logic [31:0] r = 32'h0006_0000;
        logic [31:0] p1 = 32'h000A_A001;
        mem.delete(); lat = 4;
        mem[l1_addr(r, v)] = p1;
        mem[l2_addr(p1, v)] = 32'h3333_3003;
        run_walk(v, 2'd0, r, 1'b1);
        chk("R9 only two reads", n_acc, 2);
        chk("R9 captured root", addr_log[0], l1_addr(r, v));
        chk("R9 captured vpn", addr_log[1], l2_addr(p1, v));
        chk("R9 captured access", {30'h0, got_pf, got_prot}, 32'h0);
        chk("R9 ppn", {12'h0, got_ppn}, 32'h33333);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_success_fast();
        t_success_slow();
        t_l1_fault();
        t_l2_fault();
        t_prot(2'd1, "R7 store without W");
        t_prot(2'd3, "R7 reserved access");
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule